// File: doc/BRIEF.md
# Asynchronous Static RAM Byte-Lane Controller

This block lets a clocked host read and write an external asynchronous static RAM of 128K words by 16 bits. The host raises a request with a word address, a write flag, write data and a two-bit lane mask. The controller turns that request into a timed sequence of active-low strobes: chip select, output enable, write strobe and one enable per byte lane. It then answers with a one-cycle acknowledge, and for reads it also returns the data. Every timing rule of the memory is a clock-cycle count parameter: address setup, read access, write pulse width, bus release after the write strobe falls, data hold, read-to-write turnaround and minimum access length.

The data pins are bidirectional. The controller therefore exposes its outgoing data, a drive enable per byte lane and the incoming data, and the pad ring merges them. Bit 0 of the mask selects the low lane (data bits 7:0) and bit 1 selects the high lane (bits 15:8). A masked-off lane is neither written nor driven, and it reads back as zero.

The sequencer is a state machine with these states. ST_IDLE waits for a request. ST_TURN is the read-to-write gap. ST_SETUP puts out the address with all strobes inactive. ST_RACC is the read access window. ST_WPULSE is the write strobe window. ST_WHOLD holds the data after the strobe rises. ST_PAD stretches the access to its minimum length. The transitions are:
- ST_IDLE goes to ST_SETUP on an accepted request, or to ST_TURN when a write follows a read.
- ST_TURN goes to ST_SETUP after TURN_CYC cycles.
- ST_SETUP goes to ST_RACC (read) or ST_WPULSE (write) after SETUP_CYC cycles.
- ST_RACC goes to ST_PAD after ACCESS_CYC cycles, capturing data on the edge where it leaves.
- ST_WPULSE goes to ST_WHOLD after PULSE_CYC cycles.
- ST_WHOLD goes to ST_PAD after HOLD_CYC cycles.
- ST_PAD goes to ST_IDLE once the access has lasted MIN_CYC cycles, and the acknowledge follows.

Top module: `asram_ctl`

## Requirements
- R1: After reset, chip select, output enable, write strobe and both lane enables are high, no lane drive enable is set and the acknowledge is low.
- R2: A write with mask 2'b11 stores all 16 bits, and a later read with mask 2'b11 returns the same word, including at the highest address 17'h1FFFF.
- R3: A write with mask 2'b01 changes only bits 7:0 of the stored word, and one with mask 2'b10 changes only bits 15:8.
- R4: A read returns the stored byte in every lane whose mask bit is 1 and zero in every other lane. An access with mask 2'b00 stores nothing and reads as zero.
- R5: During a read, chip select and output enable are low, the write strobe is high and lane enables follow the mask. Output enable and the write strobe are never low together.
- R6: Output enable stays high for the whole of a write. A lane drive enable is set only after the write strobe has been low for FLOAT_CYC cycles, or in the hold phase, and never while output enable is low.
- R7: Write data is driven on each enabled lane for exactly PULSE_CYC−FLOAT_CYC cycles before the write strobe rises, and stays driven in the cycle after it rises.
- R8: The memory address does not change in any cycle that follows a cycle with chip select low, while chip select is still low.
- R9: Read data is taken on the clock edge that ends the ACCESS_CYC-th cycle with output enable low.
- R10: Each accepted request yields exactly one acknowledge pulse of one cycle. Counting from the request cycle, it comes 1 + max(MIN_CYC, natural length) cycles later, plus TURN_CYC when the write follows a read. The natural length is SETUP_CYC+ACCESS_CYC+1 for a read and SETUP_CYC+PULSE_CYC+HOLD_CYC+1 for a write.
- R11: When a write follows a read, the idle gap with chip select high between the two accesses is exactly TURN_CYC cycles longer than between two back-to-back reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Request, held until acknowledge |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_mask | input | 2 | Lane mask, bit 0 low lane, bit 1 high lane |
| host_ack | output | 1 | One-cycle completion pulse |
| host_rdata | output | 16 | Read result, valid with acknowledge |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_be_n | output | 2 | Lane enables, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 2 | Drive enable per lane |
| mem_dq_in | input | 16 | Data from the memory pins |

## Verification
Full-word, single-lane and empty-mask writes are each followed by reads with every mask value. This separates a lane that is written when it should be left alone from a lane that is read back when it should return zero. The memory model returns a garbage pattern until output enable has been low for the access count, so a capture taken one edge early is detected. Reads, back-to-back reads and a read followed by a write measure the acknowledge latency and the idle gap, which exposes a missing turnaround or a missing pad. Seeded random traffic over a small address pool then mixes these cases with a shadow memory as the reference.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TURN,
        ST_SETUP,
        ST_RACC,
        ST_WPULSE,
        ST_WHOLD,
        ST_PAD
    } asram_state_e;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
    import asram_pkg::*;
#(
    parameter int SETUP_CYC  = 1,
    parameter int ACCESS_CYC = 1,
    parameter int PULSE_CYC  = 2,
    parameter int FLOAT_CYC  = 1,
    parameter int HOLD_CYC   = 1,
    parameter int TURN_CYC   = 1,
    parameter int MIN_CYC    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic req_we_i,
    output logic start_o,
    output logic cap_o,
    output logic drive_o,
    output logic ce_n_o,
    output logic oe_n_o,
    output logic we_n_o,
    output logic lane_act_o,
    output logic ack_o
);

    localparam int CMAX = imax(imax(imax(SETUP_CYC, ACCESS_CYC), imax(PULSE_CYC, HOLD_CYC)),
                               imax(TURN_CYC, MIN_CYC));
    localparam int CW = $clog2(CMAX + 1);
    localparam logic [CW-1:0] SETUP_END  = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] ACCESS_END = CW'(ACCESS_CYC - 1);
    localparam logic [CW-1:0] PULSE_END  = CW'(PULSE_CYC - 1);
    localparam logic [CW-1:0] HOLD_END   = CW'(HOLD_CYC - 1);
    localparam logic [CW-1:0] TURN_END   = CW'(TURN_CYC - 1);
    localparam logic [CW-1:0] MIN_END    = CW'(MIN_CYC - 1);
    localparam logic [CW-1:0] FLOAT_V    = CW'(FLOAT_CYC);

    asram_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] tot_q, tot_d;
    logic          op_we_q;
    logic          rd_last_q;
    logic          done;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + 1'b1;
        tot_d   = (tot_q == MIN_END) ? tot_q : tot_q + 1'b1;
        start_o = 1'b0;
        cap_o   = 1'b0;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_d = '0;
                tot_d = '0;
                if (req_i && !ack_o) begin
                    start_o = 1'b1;
                    state_d = (req_we_i && rd_last_q && (TURN_CYC > 0)) ? ST_TURN : ST_SETUP;
                end
            end
            ST_TURN: begin
                if (cnt_q == TURN_END) begin
                    cnt_d   = '0;
                    tot_d   = '0;
                    state_d = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (cnt_q == SETUP_END) begin
                    cnt_d   = '0;
                    state_d = op_we_q ? ST_WPULSE : ST_RACC;
                end
            end
            ST_RACC: begin
                if (cnt_q == ACCESS_END) begin
                    cnt_d   = '0;
                    cap_o   = 1'b1;
                    state_d = ST_PAD;
                end
            end
            ST_WPULSE: begin
                if (cnt_q == PULSE_END) begin
                    cnt_d   = '0;
                    state_d = ST_WHOLD;
                end
            end
            ST_WHOLD: begin
                if (cnt_q == HOLD_END) begin
                    cnt_d   = '0;
                    state_d = ST_PAD;
                end
            end
            ST_PAD: begin
                cnt_d = '0;
                if (tot_q == MIN_END) begin
                    done    = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tot_q   <= '0;
            op_we_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            tot_q   <= tot_d;
            if (start_o) op_we_q <= req_we_i;
        end
    end

    // registered strobes, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ce_n_o     <= 1'b1;
            oe_n_o     <= 1'b1;
            we_n_o     <= 1'b1;
            lane_act_o <= 1'b0;
            drive_o    <= 1'b0;
            ack_o      <= 1'b0;
            rd_last_q  <= 1'b0;
        end else begin
            ce_n_o     <= !(state_d == ST_RACC || state_d == ST_WPULSE);
            lane_act_o <=  (state_d == ST_RACC || state_d == ST_WPULSE);
            oe_n_o     <=  (state_d != ST_RACC);
            we_n_o     <=  (state_d != ST_WPULSE);
            drive_o    <= ((state_d == ST_WPULSE) && (cnt_d >= FLOAT_V)) || (state_d == ST_WHOLD);
            ack_o      <= done;
            if (done) rd_last_q <= !op_we_q;
        end
    end

    // R5: read and write strobes never overlap
    p_no_oe_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n_o && !we_n_o));

    // R7: data is still driven in the cycle after the write strobe rises
    p_hold_after_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n_o) |-> drive_o);

    // R9: capture only inside the output-enable window
    p_cap_in_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_o |-> (!oe_n_o && we_n_o));

    // R10: acknowledge is a single-cycle pulse
    p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |=> !ack_o);

endmodule

// File: rtl/asram_lane.sv
module asram_lane #(
    parameter int LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              en_i,
    input  logic [LANE_W-1:0] wdata_i,
    input  logic              cap_i,
    input  logic [LANE_W-1:0] din_i,
    input  logic              drive_i,
    output logic              en_o,
    output logic [LANE_W-1:0] dout_o,
    output logic              drv_o,
    output logic [LANE_W-1:0] rdata_o
);

    logic              en_q;
    logic [LANE_W-1:0] wd_q;
    logic [LANE_W-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0;
            wd_q <= '0;
            rd_q <= '0;
        end else begin
            if (start_i) begin
                en_q <= en_i;
                wd_q <= wdata_i;
            end
            if (cap_i) rd_q <= en_q ? din_i : '0;
        end
    end

    assign en_o    = en_q;
    assign dout_o  = wd_q;
    assign drv_o   = drive_i & en_q;
    assign rdata_o = rd_q;

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl #(
    parameter int ADDR_W     = 17,
    parameter int LANES      = 2,
    parameter int LANE_W     = 8,
    parameter int SETUP_CYC  = 1,
    parameter int ACCESS_CYC = 1,
    parameter int PULSE_CYC  = 2,
    parameter int FLOAT_CYC  = 1,
    parameter int HOLD_CYC   = 1,
    parameter int TURN_CYC   = 1,
    parameter int MIN_CYC    = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      host_req,
    input  logic                      host_we,
    input  logic [ADDR_W-1:0]         host_addr,
    input  logic [LANES*LANE_W-1:0]   host_wdata,
    input  logic [LANES-1:0]          host_mask,
    output logic                      host_ack,
    output logic [LANES*LANE_W-1:0]   host_rdata,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic                      mem_ce_n,
    output logic                      mem_oe_n,
    output logic                      mem_we_n,
    output logic [LANES-1:0]          mem_be_n,
    output logic [LANES*LANE_W-1:0]   mem_dq_out,
    output logic [LANES-1:0]          mem_dq_oe,
    input  logic [LANES*LANE_W-1:0]   mem_dq_in
);

    logic             start;
    logic             cap;
    logic             drive;
    logic             lane_act;
    logic [LANES-1:0] lane_en;
    logic [ADDR_W-1:0] addr_q;

    asram_seq #(
        .SETUP_CYC (SETUP_CYC),
        .ACCESS_CYC(ACCESS_CYC),
        .PULSE_CYC (PULSE_CYC),
        .FLOAT_CYC (FLOAT_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .TURN_CYC  (TURN_CYC),
        .MIN_CYC   (MIN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (host_req),
        .req_we_i  (host_we),
        .start_o   (start),
        .cap_o     (cap),
        .drive_o   (drive),
        .ce_n_o    (mem_ce_n),
        .oe_n_o    (mem_oe_n),
        .we_n_o    (mem_we_n),
        .lane_act_o(lane_act),
        .ack_o     (host_ack)
    );

    // address changes only when a new access is accepted (all strobes idle)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     addr_q <= '0;
        else if (start) addr_q <= host_addr;
    end
    assign mem_addr = addr_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        asram_lane #(.LANE_W(LANE_W)) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .start_i(start),
            .en_i   (host_mask[g]),
            .wdata_i(host_wdata[g*LANE_W +: LANE_W]),
            .cap_i  (cap),
            .din_i  (mem_dq_in[g*LANE_W +: LANE_W]),
            .drive_i(drive),
            .en_o   (lane_en[g]),
            .dout_o (mem_dq_out[g*LANE_W +: LANE_W]),
            .drv_o  (mem_dq_oe[g]),
            .rdata_o(host_rdata[g*LANE_W +: LANE_W])
        );
        assign mem_be_n[g] = ~(lane_act & lane_en[g]);
    end

    // R6: no lane is driven while the memory may be driving
    p_no_drive_on_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_dq_oe) |-> mem_oe_n);

    // R8: address holds while chip select stays low
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

    // R4: a lane enable is never low with chip select high
    p_lane_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce_n |-> (&mem_be_n));

endmodule

// File: tb/asram_ctl_bench.sv
module asram_ctl_bench;

    localparam int AW = 17;
    localparam int SU = 1;
    localparam int AC = 2;
    localparam int PW = 3;
    localparam int FL = 1;
    localparam int HD = 1;
    localparam int TN = 2;
    localparam int MN = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          h_req = 1'b0;
    logic          h_we = 1'b0;
    logic [AW-1:0] h_addr = '0;
    logic [15:0]   h_wdata = '0;
    logic [1:0]    h_mask = '0;
    logic          h_ack;
    logic [15:0]   h_rdata;
    logic [AW-1:0] m_addr;
    logic          m_ce_n, m_oe_n, m_we_n;
    logic [1:0]    m_be_n;
    logic [15:0]   m_dq_out;
    logic [1:0]    m_dq_oe;
    logic [15:0]   m_dq_in;

    asram_ctl #(
        .ADDR_W(AW), .LANES(2), .LANE_W(8),
        .SETUP_CYC(SU), .ACCESS_CYC(AC), .PULSE_CYC(PW), .FLOAT_CYC(FL),
        .HOLD_CYC(HD), .TURN_CYC(TN), .MIN_CYC(MN)
    ) u_asram_ctl (
        .clk(clk), .rst_n(rst_n),
        .host_req(h_req), .host_we(h_we), .host_addr(h_addr),
        .host_wdata(h_wdata), .host_mask(h_mask),
        .host_ack(h_ack), .host_rdata(h_rdata),
        .mem_addr(m_addr), .mem_ce_n(m_ce_n), .mem_oe_n(m_oe_n), .mem_we_n(m_we_n),
        .mem_be_n(m_be_n), .mem_dq_out(m_dq_out), .mem_dq_oe(m_dq_oe), .mem_dq_in(m_dq_in)
    );

    // memory model and shadow reference
    logic [15:0] model  [int];
    logic [15:0] shadow [int];

    function automatic logic [15:0] model_rd(input int a);
        return model.exists(a) ? model[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    function automatic int exp_lat(input logic we, input logic prev_rd);
        int nat;
        int a;
        nat = we ? (SU + PW + HD + 1) : (SU + AC + 1);
        a = (nat > MN) ? nat : MN;
        if (we && prev_rd) a = a + TN;
        return a + 1;
    endfunction

    function automatic logic [15:0] lane_mask(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    int          rd_age = 0;
    logic [15:0] drv_word = 16'hA5C3;
    logic [1:0]  mem_drv = 2'b00;
    int          wr_age [2];
    int          seen   [2];
    logic [7:0]  wbyte  [2];
    logic [1:0]  prev_act = 2'b00;
    logic        prev_ce_low = 1'b0;
    logic [AW-1:0] prev_addr = '0;
    int          idle_cnt = 0;
    int          last_gap = 0;
    int          mon_err = 0;
    int          mon_chk = 0;

    assign m_dq_in = {mem_drv[1] ? drv_word[15:8] : 8'h00,
                      mem_drv[0] ? drv_word[7:0]  : 8'h00};

    initial begin
        for (int l = 0; l < 2; l++) begin
            wr_age[l] = 0; seen[l] = 0; wbyte[l] = 8'h00;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic rdc;
            logic [1:0] act;
            rdc = !m_ce_n && !m_oe_n && m_we_n;
            // R9: data valid only after AC cycles of output enable low
            rd_age   = rdc ? rd_age + 1 : 0;
            mem_drv  = rdc ? ~m_be_n : 2'b00;
            drv_word = (rdc && rd_age >= AC) ? model_rd(int'(m_addr)) : 16'hA5C3;
            if (!m_oe_n && !m_we_n) begin
                mon_err++;
                $display("FAIL R5 actual=oe_n %b we_n %b expected=not both low", m_oe_n, m_we_n);
            end
            if (!m_ce_n && prev_ce_low && m_addr != prev_addr) begin
                mon_err++;
                $display("FAIL R8 actual=%h expected=%h", m_addr, prev_addr);
            end
            if (!m_ce_n) begin
                if (!prev_ce_low) last_gap = idle_cnt;
                idle_cnt = 0;
            end else begin
                idle_cnt++;
            end
            for (int l = 0; l < 2; l++) begin
                act[l] = !m_ce_n && !m_we_n && !m_be_n[l];
                if (m_dq_oe[l] && !m_oe_n) begin
                    mon_err++;
                    $display("FAIL R6 actual=lane %0d driven expected=off while oe low", l);
                end
                if (act[l]) begin
                    wr_age[l]++;
                    if (m_dq_oe[l]) begin
                        if (wr_age[l] <= FL) begin
                            mon_err++;
                            $display("FAIL R6 actual=drive at age %0d expected=after %0d", wr_age[l], FL);
                        end
                        seen[l]++;
                        wbyte[l] = m_dq_out[l*8 +: 8];
                    end
                end else if (prev_act[l]) begin
                    logic [15:0] w;
                    mon_chk++;
                    if (!m_dq_oe[l] || seen[l] != PW - FL) begin
                        mon_err++;
                        $display("FAIL R7 actual=setup %0d hold %b expected=setup %0d hold 1",
                                 seen[l], m_dq_oe[l], PW - FL);
                    end
                    w = model_rd(int'(m_addr));
                    w[l*8 +: 8] = wbyte[l];
                    model[int'(m_addr)] = w;
                    wr_age[l] = 0;
                    seen[l] = 0;
                end
            end
            prev_act    = act;
            prev_ce_low = !m_ce_n;
            prev_addr   = m_addr;
        end
    end

    int   errors = 0;
    int   checks = 0;
    int   wd_err = 0;
    logic prev_rd = 1'b0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic op(input logic we, input logic [AW-1:0] a, input logic [15:0] d,
                      input logic [1:0] m, input string rq);
        int lat;
        logic [15:0] exp;
        @(negedge clk);
        h_req = 1'b1; h_we = we; h_addr = a; h_wdata = d; h_mask = m;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!h_ack && lat < 100);
        h_req = 1'b0;
        chk("R10", 32'(lat), 32'(exp_lat(we, prev_rd)));
        if (we) begin
            exp = shadow_rd(int'(a));
            exp = (exp & ~lane_mask(m)) | (d & lane_mask(m));
            shadow[int'(a)] = exp;
        end else begin
            exp = shadow_rd(int'(a)) & lane_mask(m);
            chk(rq, 32'(h_rdata), 32'(exp));
        end
        prev_rd = !we;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", errors + mon_err + wd_err, checks + mon_chk + wd_err);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        wd_err = 1;
        $display("FAIL R10 actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        int g_rr;
        int g_rw;
        int seed;
        seed = $urandom(32'h5EED1234);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle pins after reset
        chk("R1", 32'(m_ce_n), 32'd1);
        chk("R1", 32'(m_oe_n), 32'd1);
        chk("R1", 32'(m_we_n), 32'd1);
        chk("R1", 32'(m_be_n), 32'd3);
        chk("R1", 32'(m_dq_oe), 32'd0);
        chk("R1", 32'(h_ack), 32'd0);

        op(1'b1, 17'h00005, 16'h1234, 2'b11, "R2");
        op(1'b0, 17'h00005, 16'h0000, 2'b11, "R2");
        op(1'b1, 17'h00005, 16'hABCD, 2'b01, "R3");
        op(1'b0, 17'h00005, 16'h0000, 2'b11, "R3");
        op(1'b1, 17'h00005, 16'h9988, 2'b10, "R3");
        op(1'b0, 17'h00005, 16'h0000, 2'b11, "R3");
        op(1'b1, 17'h00005, 16'hFFFF, 2'b00, "R4");
        op(1'b0, 17'h00005, 16'h0000, 2'b11, "R4");
        op(1'b0, 17'h00005, 16'h0000, 2'b01, "R4");
        op(1'b0, 17'h00005, 16'h0000, 2'b10, "R4");
        op(1'b0, 17'h00005, 16'h0000, 2'b00, "R4");
        op(1'b1, 17'h1FFFF, 16'hBEEF, 2'b11, "R2");
        op(1'b0, 17'h1FFFF, 16'h0000, 2'b11, "R2");
        chk("R9", 32'(h_rdata), 32'h0000BEEF);

        // R11: gap after a read, before a read and before a write
        op(1'b0, 17'h00005, 16'h0000, 2'b11, "R9");
        g_rr = last_gap;
        op(1'b1, 17'h00006, 16'h5A5A, 2'b11, "R11");
        g_rw = last_gap;
        chk("R11", 32'(g_rw - g_rr), 32'(TN));

        // random traffic over a small pool
        for (int i = 0; i < 150; i++) begin
            logic [AW-1:0] a;
            logic [1:0] m;
            logic w;
            a = ($urandom % 2 == 0) ? AW'($urandom % 16) : (17'h1FFF0 | AW'($urandom % 16));
            m = 2'($urandom % 4);
            w = 1'($urandom % 2);
            op(w, a, 16'($urandom), m, (m == 2'b11) ? "R2" : "R4");
        end

        repeat (4) @(negedge clk);
        report();
        $finish;
    end

endmodule